// File: doc/BRIEF.md
# I/O Port Address Remapper

This block turns an access in an internal I/O port space into a physical request address and attribute flags. Each request carries a port number, an access size in bytes and, for writes, a data word. The block answers in the same cycle with the physical address, an uncacheable flag, a flag that marks a hit on its own internal configuration-address register, and an error flag for port numbers that do not fit in 16 bits.

The block implements the two-port indirect configuration scheme. A 4-byte write to the address-latch port (0x0CF8) stores a 32-bit configuration address in a register inside the block; the new value takes effect at the next clock edge. Accesses to the 4-byte data window (ports 0x0CFC to 0x0CFF) go to the configuration-space region when bit 31 of that register is set, with register bits 30:2 spliced in place next to the two low port bits. When bit 31 is clear, and for every other port, the access goes to the plain I/O region at the prefix OR'ed with the port number. Both region prefixes are parameters.

Top module: `iomap_remap`

## Requirements
- R1: After reset the configuration-address register (`cfg_addr_o`) reads 0.
- R2: A valid request whose port value has any bit above bit 15 set raises `rsp_err` and drives `rsp_addr` to 0 with `rsp_uncache` and `rsp_latch_hit` low; a write with such a port leaves the register unchanged.
- R3: A valid request to port 0x0CF8 with size 4 raises `rsp_latch_hit`, keeps `rsp_uncache` low and drives `rsp_addr` to 0.
- R4: A valid write that hits the latch (R3) loads `req_wdata` into the register at the next rising clock edge; reads of the latch and writes to any other port leave the register unchanged.
- R5: A request to port 0x0CF8 with a size other than 4 uses the plain I/O mapping of R8.
- R6: A data-window request (port with its two low bits cleared equal to 0x0CFC) while register bit 31 is 1 gives `rsp_addr` = CFG_PREFIX | {register[30:2], port[1:0]} and `rsp_uncache` = 1.
- R7: A data-window request while register bit 31 is 0 gives `rsp_addr` = IO_PREFIX | port and `rsp_uncache` = 1.
- R8: Every other in-range port gives `rsp_addr` = IO_PREFIX | port, `rsp_uncache` = 1, `rsp_latch_hit` = 0.
- R9: The window covers exactly 0x0CFC to 0x0CFF: ports 0x0CFB and 0x0D00 use the plain mapping even when register bit 31 is 1.
- R10: With `req_valid` low, `rsp_addr` is 0, all response flags are low and the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | PORT_W (20) | Port number; bits above 15 must be zero |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data, used by latch writes |
| rsp_addr | output | PA_W (48) | Physical address |
| rsp_uncache | output | 1 | Access must not be cached |
| rsp_latch_hit | output | 1 | Access targets the configuration-address register |
| rsp_err | output | 1 | Port number out of the 16-bit range |
| cfg_addr_o | output | 32 | Current configuration-address register value |

## Verification
The assertions assume that inputs are settled before each rising edge and that `req_wdata` is meaningful whenever a latch write is presented; the stimulus changes all inputs only on falling edges and holds them through the following rising edge. They also take for granted that the register changes only through a qualified latch write, so the bench always returns `req_valid` low between scenarios and reads the register value back through `cfg_addr_o`. Window cases are run with bit 31 both set and clear, with register patterns that make each spliced bit visible.

// File: rtl/iomap_pkg.sv
package iomap_pkg;

    localparam int PORT_BITS = 16;
    localparam int CFG_W     = 32;

    localparam logic [PORT_BITS-1:0] LATCH_PORT  = 16'h0CF8;
    localparam logic [PORT_BITS-1:0] WINDOW_BASE = 16'h0CFC;
    localparam logic [2:0]           LATCH_SIZE  = 3'd4;

    typedef enum logic [1:0] {
        CLS_PLAIN  = 2'd0,
        CLS_LATCH  = 2'd1,
        CLS_WINDOW = 2'd2,
        CLS_BAD    = 2'd3
    } port_cls_e;

    typedef struct packed {
        logic err;
        logic latch_hit;
        logic uncache;
    } rsp_flags_t;

    function automatic port_cls_e classify(input logic [PORT_BITS-1:0] p,
                                           input logic [2:0]           sz,
                                           input logic                 high_nz);
        port_cls_e c;
        if (high_nz)
            c = CLS_BAD;
        else if (p == LATCH_PORT && sz == LATCH_SIZE)
            c = CLS_LATCH;
        else if ({p[PORT_BITS-1:2], 2'b00} == WINDOW_BASE)
            c = CLS_WINDOW;
        else
            c = CLS_PLAIN;
        return c;
    endfunction

endpackage

// File: rtl/iomap_decode.sv
module iomap_decode
    import iomap_pkg::*;
#(
    parameter int PORT_W = 20
) (
    input  logic [PORT_W-1:0]    port_in,
    input  logic [2:0]           size_in,
    output port_cls_e            cls,
    output logic [PORT_BITS-1:0] port16
);
    logic high_nz;

    generate
        if (PORT_W > PORT_BITS) begin : g_wide
            assign high_nz = |port_in[PORT_W-1:PORT_BITS];
            assign port16  = port_in[PORT_BITS-1:0];
        end else begin : g_narrow
            assign high_nz = 1'b0;
            assign port16  = PORT_BITS'(port_in);
        end
    endgenerate

    assign cls = classify(port16, size_in, high_nz);

endmodule

// File: rtl/iomap_cfg_latch.sv
module iomap_cfg_latch
    import iomap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata;
    end

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/iomap_addr_build.sv
module iomap_addr_build
    import iomap_pkg::*;
#(
    parameter int               PA_W       = 48,
    parameter logic [PA_W-1:0]  IO_PREFIX  = 48'h8000_0000_0000,
    parameter logic [PA_W-1:0]  CFG_PREFIX = 48'hC000_0000_0000
) (
    input  port_cls_e            cls,
    input  logic [PORT_BITS-1:0] port16,
    input  logic                 cfg_en,
    input  logic [30:2]          cfg_field,
    output logic [PA_W-1:0]      addr,
    output rsp_flags_t           flags
);
    logic [PA_W-1:0] io_addr;
    logic [PA_W-1:0] cfg_addr;

    assign io_addr  = IO_PREFIX | PA_W'(port16);
    assign cfg_addr = CFG_PREFIX | PA_W'({cfg_field, port16[1:0]});

    always_comb begin
        addr  = '0;
        flags = '0;
        unique case (cls)
            CLS_BAD: begin
                flags.err = 1'b1;
            end
            CLS_LATCH: begin
                flags.latch_hit = 1'b1;
            end
            CLS_WINDOW: begin
                flags.uncache = 1'b1;
                addr          = cfg_en ? cfg_addr : io_addr;
            end
            default: begin
                flags.uncache = 1'b1;
                addr          = io_addr;
            end
        endcase
    end

endmodule

// File: rtl/iomap_remap.sv
module iomap_remap
    import iomap_pkg::*;
#(
    parameter int               PORT_W     = 20,
    parameter int               PA_W       = 48,
    parameter logic [PA_W-1:0]  IO_PREFIX  = 48'h8000_0000_0000,
    parameter logic [PA_W-1:0]  CFG_PREFIX = 48'hC000_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    input  logic [CFG_W-1:0]  req_wdata,
    output logic [PA_W-1:0]   rsp_addr,
    output logic              rsp_uncache,
    output logic              rsp_latch_hit,
    output logic              rsp_err,
    output logic [CFG_W-1:0]  cfg_addr_o
);
    port_cls_e            cls;
    logic [PORT_BITS-1:0] port16;
    logic [PA_W-1:0]      raw_addr;
    rsp_flags_t           raw_flags;
    logic                 latch_we;
    logic [CFG_W-1:0]     cfg_q;

    iomap_decode #(.PORT_W(PORT_W)) u_decode (
        .port_in (req_port),
        .size_in (req_size),
        .cls     (cls),
        .port16  (port16)
    );

    iomap_addr_build #(
        .PA_W       (PA_W),
        .IO_PREFIX  (IO_PREFIX),
        .CFG_PREFIX (CFG_PREFIX)
    ) u_build (
        .cls       (cls),
        .port16    (port16),
        .cfg_en    (cfg_q[31]),
        .cfg_field (cfg_q[30:2]),
        .addr      (raw_addr),
        .flags     (raw_flags)
    );

    assign latch_we = req_valid && req_write && (cls == CLS_LATCH);

    iomap_cfg_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .we    (latch_we),
        .wdata (req_wdata),
        .q     (cfg_q)
    );

    assign rsp_addr      = req_valid ? raw_addr : '0;
    assign rsp_uncache   = req_valid && raw_flags.uncache;
    assign rsp_latch_hit = req_valid && raw_flags.latch_hit;
    assign rsp_err       = req_valid && raw_flags.err;
    assign cfg_addr_o    = cfg_q;

    // R2
    bad_port_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_addr == '0 && !rsp_uncache && !rsp_latch_hit));

    // R3
    latch_hit_attr_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_latch_hit |-> (!rsp_uncache && !rsp_err && rsp_addr == '0));

    // R2
    bad_port_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && rsp_err) |=> $stable(cfg_addr_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (rsp_addr == '0 && !rsp_uncache && !rsp_latch_hit && !rsp_err));

    // R6
    window_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_err && req_port[15:2] == 14'h033F)
            |-> (rsp_uncache && rsp_addr[1:0] == req_port[1:0]));

endmodule

// File: tb/sim_iomap_remap.sv
module sim_iomap_remap;

    localparam int PORT_W = 20;
    localparam int PA_W   = 48;
    localparam logic [PA_W-1:0] IOP  = 48'h8000_0000_0000;
    localparam logic [PA_W-1:0] CFGP = 48'hC000_0000_0000;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [PORT_W-1:0] req_port;
    logic [2:0]        req_size;
    logic              req_write;
    logic [31:0]       req_wdata;
    logic [PA_W-1:0]   rsp_addr;
    logic              rsp_uncache;
    logic              rsp_latch_hit;
    logic              rsp_err;
    logic [31:0]       cfg_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model_cfg = '0;

    always #4 clk = ~clk;

    iomap_remap u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_addr(rsp_addr), .rsp_uncache(rsp_uncache),
        .rsp_latch_hit(rsp_latch_hit), .rsp_err(rsp_err), .cfg_addr_o(cfg_addr_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_port = '0;
        req_size = 3'd0; req_wdata = '0;
    endtask

    // Drive a read at a falling edge and look at the settled outputs.
    task automatic probe(input logic [PORT_W-1:0] p, input logic [2:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_port = p; req_size = sz;
        #1;
    endtask

    task automatic expect_plain(input string req, input logic [15:0] p, input logic [2:0] sz);
        probe({4'h0, p}, sz);
        chk(req, rsp_addr, IOP | 48'(p));
        chk(req, {rsp_uncache, rsp_latch_hit, rsp_err}, 3'b100);
    endtask

    task automatic expect_window(input string req, input logic [15:0] p);
        logic [PA_W-1:0] e;
        e = model_cfg[31] ? (CFGP | 48'({model_cfg[30:2], p[1:0]})) : (IOP | 48'(p));
        probe({4'h0, p}, 3'd4);
        chk(req, rsp_addr, e);
        chk(req, {rsp_uncache, rsp_latch_hit, rsp_err}, 3'b100);
    endtask

    task automatic write_latch(input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_port = 20'h00CF8;
        req_size = 3'd4; req_wdata = d;
        #1;
        chk("R4 before edge", cfg_addr_o, model_cfg);
        @(negedge clk);
        model_cfg = d;
        chk("R4 after edge", cfg_addr_o, model_cfg);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_port = '0; req_size = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 reset value", cfg_addr_o, 32'h0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b1; req_port = 20'h00CF8;
        req_size = 3'd4; req_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R10 idle addr", rsp_addr, 48'h0);
        chk("R10 idle flags", {rsp_uncache, rsp_latch_hit, rsp_err}, 3'b000);
        @(negedge clk);
        chk("R10 idle no load", cfg_addr_o, model_cfg);
        idle();
    endtask

    task automatic t_plain();
        expect_plain("R8 port 0x0060", 16'h0060, 3'd1);
        expect_plain("R8 port 0xFFFF", 16'hFFFF, 3'd2);
        expect_plain("R8 port 0x0000", 16'h0000, 3'd4);
        idle();
    endtask

    task automatic t_latch_hit();
        probe(20'h00CF8, 3'd4);
        chk("R3 latch addr", rsp_addr, 48'h0);
        chk("R3 latch flags", {rsp_uncache, rsp_latch_hit, rsp_err}, 3'b010);
        @(negedge clk);
        chk("R4 latch read no load", cfg_addr_o, model_cfg);
        idle();
    endtask

    task automatic t_latch_sizes();
        expect_plain("R5 latch port size 1", 16'h0CF8, 3'd1);
        expect_plain("R5 latch port size 2", 16'h0CF8, 3'd2);
        idle();
    endtask

    task automatic t_window_off();
        write_latch(32'h7FFF_FFFC);
        for (int i = 0; i < 4; i++)
            expect_window("R7 window disabled", 16'h0CFC + 16'(i));
        idle();
    endtask

    task automatic t_window_on();
        write_latch(32'h8012_3457);
        for (int i = 0; i < 4; i++)
            expect_window("R6 window enabled", 16'h0CFC + 16'(i));
        write_latch(32'hAAAA_5555);
        expect_window("R6 window alt pattern", 16'h0CFE);
        write_latch(32'hFFFF_FFFF);
        expect_window("R6 window all ones", 16'h0CFD);
        idle();
    endtask

    task automatic t_window_edges();
        expect_plain("R9 below window", 16'h0CFB, 3'd4);
        expect_plain("R9 above window", 16'h0D00, 3'd4);
        expect_plain("R9 alias 0x1CFC", 16'h1CFC, 3'd4);
        idle();
    endtask

    task automatic t_other_writes();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_port = 20'h00CFC;
        req_size = 3'd4; req_wdata = 32'h1234_5678;
        @(negedge clk);
        chk("R4 window write no load", cfg_addr_o, model_cfg);
        req_port = 20'h00CF8; req_size = 3'd2;
        @(negedge clk);
        chk("R4 narrow latch write no load", cfg_addr_o, model_cfg);
        idle();
    endtask

    task automatic t_bad_port();
        probe(20'h10CF8, 3'd4);
        chk("R2 bad addr", rsp_addr, 48'h0);
        chk("R2 bad flags", {rsp_uncache, rsp_latch_hit, rsp_err}, 3'b001);
        probe(20'h80060, 3'd1);
        chk("R2 bad top bit", {rsp_uncache, rsp_latch_hit, rsp_err}, 3'b001);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_port = 20'h10CF8;
        req_size = 3'd4; req_wdata = 32'h0BAD_0BAD;
        @(negedge clk);
        chk("R2 bad write no load", cfg_addr_o, model_cfg);
        idle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_idle();
        t_plain();
        t_latch_hit();
        t_latch_sizes();
        t_window_off();
        t_window_on();
        t_window_edges();
        t_other_writes();
        t_bad_port();
        write_latch(32'h0000_0000);
        expect_window("R7 window after clear", 16'h0CFF);
        idle();
        finish_run();
    end

endmodule